// File: doc/BRIEF.md
# Byte-Serial Preset Counter

This block is a 24-bit up/down event counter for a host that sees only two 8-bit ports: a data port and a control port. The counter cannot be written directly. The host fills a preset register one byte at a time and then issues a transfer command. To read the count, the host first copies the live value into an output latch and then reads that latch byte by byte. One byte pointer serves both directions. The host can clear it, and it steps after every data access.

Count-up and count-down strobes and an index input come from an input conditioner outside this block. Four count modes set what happens at the ends of the range: normal wrap, range-limit, non-recycle and modulo-N. Two toggle flags, one for borrow and one for carry, extend the readable range. Their XOR acts as a 25th count bit. An index edge can reload the preset into the counter. Of the preset's low byte, one copy can go to the filter prescaler that sits upstream.

Top module: `bytewise_tally`

## Requirements
- R1: Control-port bits [7:5] select the target: 000 reset/load command, 001 count mode, 010 input control, 011 index control. A control write with bit 7 set has no effect.
- R2: A data write stores the byte into the preset at the byte pointer, least significant byte first, and advances the pointer, which wraps from 2 to 0. A reset/load command with bit 0 set returns the pointer to 0. That bit combines with the other command fields.
- R3: A data read returns the output-latch byte at the pointer and advances the pointer. A reset/load command with bits [4:3] = 10 copies the counter into the latch.
- R4: The counter changes only as follows. Bits [4:3] = 01 loads the preset into it. Bits [2:1] = 01 clears it to 0. An index load or a count step also changes it. Data writes leave it untouched.
- R5: Count-mode bits [2:1] = 0 select normal mode, which wraps 0xFFFFFF to 0 and toggles carry, and wraps 0 to 0xFFFFFF and toggles borrow. A strobe counts only when input-control bit 0 is 1 and exactly one of up and down is high.
- R6: A control-port read returns the status byte: bit 0 borrow, bit 1 carry, bit 4 noise error, bit 5 direction of the last step (1 = up), other bits 0. Command bits [2:1] = 10 clear borrow and carry. Bits [2:1] = 11 clear the error flag. A noise pulse sets the error flag.
- R7: Modulo-N (mode 3): an up step at or above the ceiling (the preset) reloads 0 and toggles carry. A down step at 0 reloads the ceiling and toggles borrow.
- R8: Range-limit (mode 1): an up step at or above the ceiling and a down step at 0 leave the count unchanged.
- R9: Non-recycle (mode 2) wraps like normal mode. After a wrap it ignores strobes until the counter is cleared, loaded from the preset or index-loaded.
- R10: With input-control bit 1 = 0 (active-low preset enable) and bit 0 = 1, an index edge loads the preset into the counter. Index-control bit 1 chooses the edge: 1 rising, 0 falling.
- R11: With index-control bit 0 = 1 (synchronous), an index edge loads only in a cycle that also carries a single count strobe.
- R12: When events meet in one cycle, a host control-port write wins over an index load, and an index load wins over a count step. The losing events are dropped.
- R13: A reset/load command with bits [4:3] = 11 copies the preset's low byte to the prescaler output.
- R14: After reset all registers are zero: count, preset, latch, pointer, flags, modes, inputs disabled and index function off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_ctl | input | 1 | Port select: 1 control/status, 0 data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or latch byte at the pointer |
| cnt_up | input | 1 | Count-up strobe |
| cnt_dn | input | 1 | Count-down strobe |
| idx_in | input | 1 | Index level, already filtered |
| noise_hit | input | 1 | Noise-detected pulse from the input filter |
| flt_div | output | 8 | Prescaler value for the input filter |

## Verification
The bench builds the block with its default three-byte width, so every register holds its full 24 bits. Presets such as 0xFFFFFE, 0xFFFFFF and 5 put the counter one step from each range end without long count runs. Each mode's wrap, freeze and halt behaviour is therefore reached in a handful of strobes. The same short reach covers the pointer wrap on the fourth data byte and the three-way collision of a host write, an index edge and a count strobe.

// File: rtl/tally_pkg.sv
package tally_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CM_NORMAL  = 2'd0,
    CM_RANGE   = 2'd1,
    CM_NORECYC = 2'd2,
    CM_MODN    = 2'd3
  } cmode_e;

  typedef struct packed {
    logic host_busy;
    logic bp_rst;
    logic cnt_clr;
    logic flg_clr;
    logic err_clr;
    logic ld_cnt;
    logic ld_latch;
    logic ld_psc;
    logic wr_mode;
    logic wr_io;
    logic wr_idx;
  } cmd_t;
endpackage

// File: rtl/tally_decode.sv
module tally_decode
  import tally_pkg::*;
(
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] wbyte,
  output cmd_t              cmd
);
  logic [2:0] target;
  logic       is_rld;

  assign target = wbyte[7:5];
  assign is_rld = ctl_wr && (target == 3'd0);

  always_comb begin
    cmd           = '0;
    cmd.host_busy = ctl_wr;
    cmd.bp_rst    = is_rld && wbyte[0];
    cmd.cnt_clr   = is_rld && (wbyte[2:1] == 2'b01);
    cmd.flg_clr   = is_rld && (wbyte[2:1] == 2'b10);
    cmd.err_clr   = is_rld && (wbyte[2:1] == 2'b11);
    cmd.ld_cnt    = is_rld && (wbyte[4:3] == 2'b01);
    cmd.ld_latch  = is_rld && (wbyte[4:3] == 2'b10);
    cmd.ld_psc    = is_rld && (wbyte[4:3] == 2'b11);
    cmd.wr_mode   = ctl_wr && (target == 3'd1);
    cmd.wr_io     = ctl_wr && (target == 3'd2);
    cmd.wr_idx    = ctl_wr && (target == 3'd3);
  end
endmodule

// File: rtl/tally_bytes.sv
module tally_bytes
  import tally_pkg::*;
#(
  parameter int NBYTES = 3,
  parameter int CW     = NBYTES * BYTE_W,
  parameter int PW     = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              bp_rst,
  input  logic              ld_latch,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [CW-1:0]     count_q,
  output logic [CW-1:0]     preset_q,
  output logic [PW-1:0]     bp_q,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam logic [PW-1:0] LAST = PW'(NBYTES - 1);

  logic [CW-1:0] latch_q;

  // pointer: reset by command, stepped by any data access, wraps after the top byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bp_q <= '0;
    else if (bp_rst)           bp_q <= '0;
    else if (data_wr || data_rd)
      bp_q <= (bp_q == LAST) ? '0 : bp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) preset_q <= '0;
    else begin
      for (int i = 0; i < NBYTES; i++)
        if (data_wr && bp_q == PW'(i)) preset_q[i*BYTE_W +: BYTE_W] <= wbyte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (ld_latch) latch_q <= count_q;
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NBYTES; i++)
      if (bp_q == PW'(i)) rd_byte = latch_q[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/tally_core.sv
module tally_core
  import tally_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_busy,
  input  logic              cnt_clr,
  input  logic              flg_clr,
  input  logic              err_clr,
  input  logic              ld_cnt,
  input  logic              ld_psc,
  input  logic              wr_mode,
  input  logic              wr_io,
  input  logic              wr_idx,
  input  logic [2:0]        cfg,
  input  logic [CW-1:0]     preset_q,
  input  logic              cnt_up,
  input  logic              cnt_dn,
  input  logic              idx_in,
  input  logic              noise_hit,
  output logic [CW-1:0]     count_q,
  output logic              borrow_q,
  output logic              carry_q,
  output logic              err_q,
  output logic              updir_q,
  output logic              halt_q,
  output cmode_e            mode_q,
  output logic [BYTE_W-1:0] psc_q,
  output logic              idx_ld,
  output logic              step_up,
  output logic              step_dn,
  output logic              ev_ovf,
  output logic              ev_unf
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic ab_q, pre_n_q, sync_q, pol_q, idx_prev_q;
  logic idx_edge;
  logic [CW:0] up_res, dn_res;

  // {wrap, next value} for an up step
  function automatic logic [CW:0] next_up(input logic [CW-1:0] c,
                                          input logic [CW-1:0] ceil,
                                          input cmode_e m);
    case (m)
      CM_RANGE: next_up = (c >= ceil) ? {1'b0, c} : {1'b0, c + 1'b1};
      CM_MODN:  next_up = (c >= ceil) ? {1'b1, {CW{1'b0}}} : {1'b0, c + 1'b1};
      default:  next_up = (c == TOP)  ? {1'b1, {CW{1'b0}}} : {1'b0, c + 1'b1};
    endcase
  endfunction

  // {wrap, next value} for a down step
  function automatic logic [CW:0] next_dn(input logic [CW-1:0] c,
                                          input logic [CW-1:0] ceil,
                                          input cmode_e m);
    case (m)
      CM_RANGE: next_dn = (c == '0) ? {1'b0, c}    : {1'b0, c - 1'b1};
      CM_MODN:  next_dn = (c == '0) ? {1'b1, ceil} : {1'b0, c - 1'b1};
      default:  next_dn = (c == '0) ? {1'b1, TOP}  : {1'b0, c - 1'b1};
    endcase
  endfunction

  assign up_res   = next_up(count_q, preset_q, mode_q);
  assign dn_res   = next_dn(count_q, preset_q, mode_q);
  assign idx_edge = pol_q ? (idx_in & ~idx_prev_q) : (~idx_in & idx_prev_q);
  assign idx_ld   = idx_edge & ab_q & ~pre_n_q & ~host_busy
                  & (~sync_q | (cnt_up ^ cnt_dn));
  assign step_up  = ab_q & cnt_up & ~cnt_dn & ~host_busy & ~idx_ld & ~halt_q;
  assign step_dn  = ab_q & cnt_dn & ~cnt_up & ~host_busy & ~idx_ld & ~halt_q;
  assign ev_ovf   = step_up & up_res[CW];
  assign ev_unf   = step_dn & dn_res[CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      borrow_q <= 1'b0;
      carry_q  <= 1'b0;
      halt_q   <= 1'b0;
      updir_q  <= 1'b0;
    end else begin
      if (cnt_clr || ld_cnt) begin
        count_q <= ld_cnt ? preset_q : '0;
        halt_q  <= 1'b0;
      end else if (idx_ld) begin
        count_q <= preset_q;
        halt_q  <= 1'b0;
      end else if (step_up) begin
        count_q <= up_res[CW-1:0];
        updir_q <= 1'b1;
        if (ev_ovf) begin
          carry_q <= ~carry_q;
          if (mode_q == CM_NORECYC) halt_q <= 1'b1;
        end
      end else if (step_dn) begin
        count_q <= dn_res[CW-1:0];
        updir_q <= 1'b0;
        if (ev_unf) begin
          borrow_q <= ~borrow_q;
          if (mode_q == CM_NORECYC) halt_q <= 1'b1;
        end
      end
      if (flg_clr) begin
        borrow_q <= 1'b0;
        carry_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (noise_hit) err_q <= 1'b1;
    else if (err_clr)   err_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= CM_NORMAL;
      ab_q       <= 1'b0;
      pre_n_q    <= 1'b0;
      sync_q     <= 1'b0;
      pol_q      <= 1'b0;
      idx_prev_q <= 1'b0;
      psc_q      <= '0;
    end else begin
      idx_prev_q <= idx_in;
      if (wr_mode) mode_q <= cmode_e'(cfg[2:1]);
      if (wr_io) begin
        ab_q    <= cfg[0];
        pre_n_q <= cfg[1];
      end
      if (wr_idx) begin
        sync_q <= cfg[0];
        pol_q  <= cfg[1];
      end
      if (ld_psc) psc_q <= preset_q[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/bytewise_tally.sv
module bytewise_tally
  import tally_pkg::*;
#(
  parameter int NBYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_ctl,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              cnt_up,
  input  logic              cnt_dn,
  input  logic              idx_in,
  input  logic              noise_hit,
  output logic [BYTE_W-1:0] flt_div
);
  localparam int CW = NBYTES * BYTE_W;
  localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic              ctl_wr, data_wr, data_rd;
  cmd_t              cmd;
  logic [CW-1:0]     count_q, preset_q;
  logic [PW-1:0]     bp_q;
  logic [BYTE_W-1:0] rd_byte, status;
  logic              borrow_q, carry_q, err_q, updir_q, halt_q;
  cmode_e            mode_q;
  logic              idx_ld, step_up, step_dn, ev_ovf, ev_unf;

  assign ctl_wr  = host_wr & host_ctl;
  assign data_wr = host_wr & ~host_ctl;
  assign data_rd = host_rd & ~host_ctl;

  tally_decode u_dec (
    .ctl_wr (ctl_wr),
    .wbyte  (host_wdata),
    .cmd    (cmd)
  );

  tally_bytes #(.NBYTES(NBYTES), .CW(CW), .PW(PW)) u_bytes (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .bp_rst   (cmd.bp_rst),
    .ld_latch (cmd.ld_latch),
    .wbyte    (host_wdata),
    .count_q  (count_q),
    .preset_q (preset_q),
    .bp_q     (bp_q),
    .rd_byte  (rd_byte)
  );

  tally_core #(.CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_busy (cmd.host_busy),
    .cnt_clr   (cmd.cnt_clr),
    .flg_clr   (cmd.flg_clr),
    .err_clr   (cmd.err_clr),
    .ld_cnt    (cmd.ld_cnt),
    .ld_psc    (cmd.ld_psc),
    .wr_mode   (cmd.wr_mode),
    .wr_io     (cmd.wr_io),
    .wr_idx    (cmd.wr_idx),
    .cfg       (host_wdata[2:0]),
    .preset_q  (preset_q),
    .cnt_up    (cnt_up),
    .cnt_dn    (cnt_dn),
    .idx_in    (idx_in),
    .noise_hit (noise_hit),
    .count_q   (count_q),
    .borrow_q  (borrow_q),
    .carry_q   (carry_q),
    .err_q     (err_q),
    .updir_q   (updir_q),
    .halt_q    (halt_q),
    .mode_q    (mode_q),
    .psc_q     (flt_div),
    .idx_ld    (idx_ld),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .ev_ovf    (ev_ovf),
    .ev_unf    (ev_unf)
  );

  assign status     = {2'b00, updir_q, err_q, 2'b00, carry_q, borrow_q};
  assign host_rdata = host_ctl ? status : rd_byte;
endmodule

// File: rtl/tally_chk.sv
module tally_chk
  import tally_pkg::*;
#(
  parameter int CW = 24,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic          bp_rst,
  input logic          cnt_clr,
  input logic          ld_cnt,
  input logic          flg_clr,
  input logic [PW-1:0] bp_q,
  input logic [CW-1:0] count_q,
  input logic [CW-1:0] preset_q,
  input logic          carry_q,
  input logic          borrow_q,
  input logic          halt_q,
  input cmode_e        mode_q,
  input logic          idx_ld,
  input logic          step_dn,
  input logic          ev_ovf,
  input logic          ev_unf
);
  // R2
  bp_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bp_rst |=> (bp_q == '0));

  // R12
  host_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !cnt_clr && !ld_cnt) |=> (count_q == $past(count_q)));

  // R6
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_ovf && !flg_clr) |=> $stable(carry_q));

  // R6
  borrow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_unf && !flg_clr) |=> $stable(borrow_q));

  // R8
  range_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CM_RANGE && step_dn && count_q == '0) |=> (count_q == '0));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !cnt_clr && !ld_cnt && !idx_ld) |=> $stable(count_q));

  // R10
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ld |=> (count_q == $past(preset_q)));
endmodule

bind bytewise_tally tally_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_wr   (ctl_wr),
  .bp_rst   (cmd.bp_rst),
  .cnt_clr  (cmd.cnt_clr),
  .ld_cnt   (cmd.ld_cnt),
  .flg_clr  (cmd.flg_clr),
  .bp_q     (bp_q),
  .count_q  (count_q),
  .preset_q (preset_q),
  .carry_q  (carry_q),
  .borrow_q (borrow_q),
  .halt_q   (halt_q),
  .mode_q   (mode_q),
  .idx_ld   (idx_ld),
  .step_dn  (step_dn),
  .ev_ovf   (ev_ovf),
  .ev_unf   (ev_unf)
);

// File: tb/sim_bytewise_tally.sv
`timescale 1ns/1ps
module sim_bytewise_tally;
  localparam int TOPV = 24'hFFFFFF;

  logic       clk = 1'b0;
  logic       rst_n, host_wr, host_rd, host_ctl, cnt_up, cnt_dn, idx_in, noise_hit;
  logic [7:0] host_wdata, host_rdata, flt_div;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bytewise_tally u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_ctl(host_ctl), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cnt_up(cnt_up), .cnt_dn(cnt_dn), .idx_in(idx_in),
    .noise_hit(noise_hit), .flt_div(flt_div)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_pre, m_lat, m_bp, m_mode, m_psc;
  bit m_br, m_cr, m_err, m_ud, m_halt, m_ab, m_pren, m_sync, m_pol, m_iprev;

  always @(posedge clk) begin : model
    bit cw, dw, dr, ild, one;
    int b, old;
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_lat = 0; m_bp = 0; m_mode = 0; m_psc = 0;
      m_br = 0; m_cr = 0; m_err = 0; m_ud = 0; m_halt = 0;
      m_ab = 0; m_pren = 0; m_sync = 0; m_pol = 0; m_iprev = 0;
    end else begin
      cw  = host_wr && host_ctl;
      dw  = host_wr && !host_ctl;
      dr  = host_rd && !host_ctl;
      b   = host_wdata;
      one = (cnt_up != cnt_dn);
      old = m_cnt;
      ild = (m_pol ? (idx_in && !m_iprev) : (!idx_in && m_iprev))
            && m_ab && !m_pren && !cw && (!m_sync || one);
      if (cw) begin
        if ((b >> 5) == 0) begin
          if (((b >> 1) & 3) == 1) begin m_cnt = 0; m_halt = 0; end
          if (((b >> 3) & 3) == 1) begin m_cnt = m_pre; m_halt = 0; end
          if (((b >> 1) & 3) == 2) begin m_br = 0; m_cr = 0; end
          if (((b >> 1) & 3) == 3) m_err = 0;
          if (((b >> 3) & 3) == 2) m_lat = old;
          if (((b >> 3) & 3) == 3) m_psc = m_pre % 256;
          if (b % 2 == 1) m_bp = 0;
        end
      end else if (ild) begin
        m_cnt = m_pre; m_halt = 0;
      end else if (m_ab && one && !m_halt) begin
        if (cnt_up) begin
          m_ud = 1;
          if ((m_mode == 1 || m_mode == 3) && m_cnt >= m_pre) begin
            if (m_mode == 3) begin m_cnt = 0; m_cr = !m_cr; end
          end else if (m_mode != 1 && m_mode != 3 && m_cnt == TOPV) begin
            m_cnt = 0; m_cr = !m_cr; if (m_mode == 2) m_halt = 1;
          end else m_cnt = m_cnt + 1;
        end else begin
          m_ud = 0;
          if (m_cnt == 0) begin
            if (m_mode == 3) begin m_cnt = m_pre; m_br = !m_br; end
            else if (m_mode != 1) begin
              m_cnt = TOPV; m_br = !m_br; if (m_mode == 2) m_halt = 1;
            end
          end else m_cnt = m_cnt - 1;
        end
      end
      if (noise_hit) m_err = 1;
      if (cw && (b >> 5) == 1) m_mode = (b >> 1) & 3;
      if (cw && (b >> 5) == 2) begin m_ab = b[0]; m_pren = b[1]; end
      if (cw && (b >> 5) == 3) begin m_sync = b[0]; m_pol = b[1]; end
      if (dw) m_pre = (m_pre & ~(255 << (8 * m_bp))) | (b << (8 * m_bp));
      if (dw || dr) m_bp = (m_bp == 2) ? 0 : m_bp + 1;
      m_iprev = idx_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (host_ctl)
        chk("R6 model status", host_rdata,
            {26'd0, m_ud, m_err, 2'b00, m_cr, m_br});
      else
        chk("R3 model data", host_rdata, (m_lat >> (8 * m_bp)) & 255);
      chk("R13 model prescaler", flt_div, m_psc);
    end
  end

  // ---------------- host tasks ----------------
  task automatic cwr(input logic [7:0] b);
    host_wr = 1; host_ctl = 1; host_wdata = b;
    @(posedge clk); #1;
    host_wr = 0; host_ctl = 0;
  endtask

  task automatic dwr(input logic [7:0] b);
    host_wr = 1; host_ctl = 0; host_wdata = b;
    @(posedge clk); #1;
    host_wr = 0;
  endtask

  task automatic drd(output int v);
    host_rd = 1; host_ctl = 0;
    @(negedge clk); v = host_rdata;
    @(posedge clk); #1;
    host_rd = 0;
  endtask

  task automatic stat(output int s);
    host_ctl = 1;
    @(negedge clk); s = host_rdata;
    @(posedge clk); #1;
    host_ctl = 0;
  endtask

  task automatic rdcnt(output int v);
    int b0, b1, b2;
    cwr(8'h11);
    drd(b0); drd(b1); drd(b2);
    v = b0 | (b1 << 8) | (b2 << 16);
  endtask

  task automatic setpre(input int v);
    cwr(8'h01);
    dwr(v[7:0]); dwr(v[15:8]); dwr(v[23:16]);
  endtask

  task automatic up(input int n);
    for (int i = 0; i < n; i++) begin cnt_up = 1; @(posedge clk); #1; cnt_up = 0; end
  endtask

  task automatic dn(input int n);
    for (int i = 0; i < n; i++) begin cnt_dn = 1; @(posedge clk); #1; cnt_dn = 0; end
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog R14 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int v, s;
    rst_n = 0; host_wr = 0; host_rd = 0; host_ctl = 0; host_wdata = 0;
    cnt_up = 0; cnt_dn = 0; idx_in = 0; noise_hit = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;

    // R14 reset state
    stat(s);  chk("R14 reset status", s, 0);
    chk("R14 reset prescaler", flt_div, 0);
    drd(v);   chk("R14 reset latch byte", v, 0);

    // R2 R3 R4 byte-serial load and read
    setpre(24'h123456);
    rdcnt(v); chk("R4 data writes leave count", v, 0);
    cwr(8'h08);
    rdcnt(v); chk("R4 preset transfer", v, 24'h123456);

    // R2 pointer wrap: fourth byte lands in byte 0
    cwr(8'h01);
    dwr(8'hAA); dwr(8'hBB); dwr(8'hCC); dwr(8'hDD);
    cwr(8'h08);
    rdcnt(v); chk("R2 pointer wrap write", v, 24'hCCBBDD);
    drd(v);   chk("R3 pointer wrap read", v, 8'hDD);

    // R5 normal wrap with toggles
    cwr(8'h43);
    setpre(24'hFFFFFE); cwr(8'h08);
    up(3);
    stat(s);  chk("R5 overflow status", s, 8'h22);
    rdcnt(v); chk("R5 overflow value", v, 1);
    dn(2);
    stat(s);  chk("R5 underflow status", s, 8'h03);
    rdcnt(v); chk("R5 underflow value", v, 24'hFFFFFF);
    cwr(8'h04);
    stat(s);  chk("R6 flag clear", s, 0);

    // R7 modulo-N
    cwr(8'h26);
    setpre(5); cwr(8'h08);
    up(1);
    rdcnt(v); chk("R7 up past ceiling", v, 0);
    dn(1);
    rdcnt(v); chk("R7 down below zero", v, 5);
    stat(s);  chk("R7 toggles", s, 8'h03);
    cwr(8'h04);

    // R8 range-limit
    cwr(8'h22);
    up(2);
    rdcnt(v); chk("R8 hold at ceiling", v, 5);
    stat(s);  chk("R8 no toggle up", s, 8'h20);
    cwr(8'h02);
    dn(2);
    rdcnt(v); chk("R8 hold at zero", v, 0);
    stat(s);  chk("R8 no toggle down", s, 0);

    // R9 non-recycle
    cwr(8'h24);
    setpre(24'hFFFFFF); cwr(8'h08);
    up(3);
    rdcnt(v); chk("R9 halted after wrap", v, 0);
    stat(s);  chk("R9 carry after wrap", s, 8'h22);
    cwr(8'h08);
    dn(1);
    rdcnt(v); chk("R9 resumes after load", v, 24'hFFFFFE);
    cwr(8'h04);

    // R10 index load, both polarities
    cwr(8'h20);
    setpre(24'h000100);
    cwr(8'h02);
    cwr(8'h41);
    cwr(8'h62);
    idx_in = 1; @(posedge clk); #1;
    rdcnt(v); chk("R10 rising index load", v, 24'h100);
    up(3);
    cwr(8'h60);
    idx_in = 0; @(posedge clk); #1;
    rdcnt(v); chk("R10 falling index load", v, 24'h100);

    // R11 synchronous index
    up(5);
    cwr(8'h63);
    idx_in = 1; @(posedge clk); #1;
    rdcnt(v); chk("R11 sync needs strobe", v, 24'h105);
    idx_in = 0; @(posedge clk); #1;
    idx_in = 1; cnt_up = 1; @(posedge clk); #1; cnt_up = 0;
    rdcnt(v); chk("R12 index beats count", v, 24'h100);

    // R12 host write beats index and count
    idx_in = 0; @(posedge clk); #1;
    up(2);
    idx_in = 1; cnt_up = 1;
    host_wr = 1; host_ctl = 1; host_wdata = 8'h63;
    @(posedge clk); #1;
    cnt_up = 0; host_wr = 0; host_ctl = 0;
    rdcnt(v); chk("R12 host beats index and count", v, 24'h102);

    // R5 gating by enable and by double strobe
    cwr(8'h42);
    up(3);
    rdcnt(v); chk("R5 inputs disabled", v, 24'h102);
    cwr(8'h43);
    cnt_up = 1; cnt_dn = 1; @(posedge clk); #1; cnt_up = 0; cnt_dn = 0;
    rdcnt(v); chk("R5 both strobes", v, 24'h102);

    // R1 unused targets ignored
    cwr(8'h82); cwr(8'hC2); cwr(8'hA2);
    rdcnt(v); chk("R1 unused target", v, 24'h102);

    // R6 noise error
    noise_hit = 1; @(posedge clk); #1; noise_hit = 0;
    stat(s);  chk("R6 error set", s, 8'h30);
    cwr(8'h06);
    stat(s);  chk("R6 error cleared", s, 8'h20);

    // R13 prescaler
    setpre(24'h00007B);
    cwr(8'h18);
    @(negedge clk);
    chk("R13 prescaler copy", flt_div, 8'h7B);
    @(posedge clk); #1;

    done = 1;
    summary();
    $finish;
  end
endmodule